// File: doc/BRIEF.md
# Word-Serial Message Device Responder

This block is the slave end of a word-serial message exchange on a 16-bit register bus. A bus commander talks to it through two registers. It polls a status register for handshake flags. It then writes command words into a single data register, or reads a reply byte from that register. An inbound byte arrives as a "Byte Available" command word, with the byte in the low half and an end-of-message flag in the command code. An outbound byte is fetched by writing the "Byte Request" command word. After the request, the commander waits for the read-ready flag and reads the byte back from the same data register.

On the device side, inbound bytes are presented on a valid/take port until local logic consumes them. Outbound bytes are pulled from a source port that shows a valid byte. Only the two defined offsets answer. Any other offset returns a bus error in the same cycle and has no effect. Malformed or out-of-turn command words are dropped, and they raise a sticky error flag.

Top module: `ws_responder`

## Requirements
- R1: The Response register reads DOR at bit 13 (high while `out_valid` is high), DIR at bit 12 (high while no inbound byte is pending), Read Ready at bit 10 and Write Ready at bit 9. Every other bit reads 1. After reset, with `out_valid` low, it reads 16'hDBFF.
- R2: A Data Low write of 16'hBCxx or 16'hBDxx while Write Ready and DIR are high is accepted. From the next cycle, `in_valid` is high, `in_data` holds bits 7:0 of the word, and `in_end` holds bit 8 (1 for BD, 0 for BC).
- R3: After an accepted Byte Available command, Write Ready reads 0 for exactly one cycle and then returns to 1.
- R4: A Data Low write of 16'hDEFF while Write Ready and DOR are high is accepted. In the next cycle `out_take` pulses for one cycle and Write Ready reads 0. On the clock edge that ends the pulse, `out_data` is latched, and Read Ready and Write Ready both become 1.
- R5: A Data Low read returns {8'h00, latched byte} and clears Read Ready.
- R6: A Byte Request written while DOR is low is ignored. No `out_take` pulse follows, Read Ready stays 0, Write Ready stays 1 and `cmd_err` is not set.
- R7: An access to any offset other than Response (6'h0A) or Data Low (6'h0E) raises `bus_err` in the same cycle and reads 16'h0000. It does not change any flag, perform any command or set `cmd_err`. The two defined offsets never raise `bus_err`.
- R8: A Data Low write matching neither command code is dropped and sets `cmd_err`. `cmd_err` then stays 1 until reset.
- R9: A command written while Write Ready is low, or a Byte Available written while DIR is low, is dropped and sets `cmd_err`. The pending inbound byte is kept unchanged.
- R10: Writes to the Response offset are ignored: no flag changes and `cmd_err` is not set.
- R11: A pending inbound byte stays stable on `in_data` until `in_take` is sampled high. DIR reads 1 from the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| bus_err | output | 1 | Bus error for undefined offsets, same cycle |
| in_valid | output | 1 | Inbound byte pending |
| in_data | output | 8 | Inbound byte |
| in_end | output | 1 | Inbound byte ends a message |
| in_take | input | 1 | Local logic consumes the inbound byte |
| out_valid | input | 1 | Outbound source has a byte |
| out_data | input | 8 | Outbound byte from the source |
| out_take | output | 1 | One-cycle pulse consuming the outbound byte |
| cmd_err | output | 1 | Sticky command error |

## Verification
The bench places the Byte Request fetch under an exact cycle count. It checks `out_take`, Write Ready and Read Ready in the cycle between the command edge and the latch edge. A design that raises Read Ready before the byte is latched, or drops the ready flag late, fails there. The bench issues a Byte Request with the source empty, writes to the Response offset and touches undefined offsets. In each case it confirms through the Response register and `cmd_err` that nothing moved, so a design that half-executes those commands is caught. It also overruns a pending inbound byte and confirms the old byte survives. This catches a buffer that overwrites instead of refusing.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  localparam int DOR_BIT  = 13;
  localparam int DIR_BIT  = 12;
  localparam int RRDY_BIT = 10;
  localparam int WRDY_BIT = 9;

  localparam logic [BUS_W-1:0] BREQ_WORD = 16'hDEFF;
  localparam logic [6:0]       BAVL_TOP  = 7'b1011110; // BC/BD share bits 15:9

  typedef enum logic [1:0] {
    WS_CMD_BAD  = 2'd0,
    WS_CMD_BREQ = 2'd1,
    WS_CMD_BAVL = 2'd2
  } ws_cmd_e;

  function automatic ws_cmd_e classify(input logic [BUS_W-1:0] w);
    if (w == BREQ_WORD)           return WS_CMD_BREQ;
    else if (w[15:9] == BAVL_TOP) return WS_CMD_BAVL;
    else                          return WS_CMD_BAD;
  endfunction

  function automatic logic [BUS_W-1:0] resp_word(input logic dor, input logic dir,
                                                 input logic rrdy, input logic wrdy);
    logic [BUS_W-1:0] w;
    w = '1;
    w[DOR_BIT]  = dor;
    w[DIR_BIT]  = dir;
    w[RRDY_BIT] = rrdy;
    w[WRDY_BIT] = wrdy;
    return w;
  endfunction
endpackage

// File: rtl/ws_addr_dec.sv
module ws_addr_dec #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] RESP_OFF = 6'h0A,
  parameter logic [ADDR_W-1:0] DLOW_OFF = 6'h0E
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_resp,
  output logic              hit_dlow,
  output logic              miss
);
  always_comb begin
    hit_resp = sel && (addr == RESP_OFF);
    hit_dlow = sel && (addr == DLOW_OFF);
    miss     = sel && !hit_resp && !hit_dlow;
  end
endmodule

// File: rtl/ws_inbound.sv
module ws_inbound #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              load_end,
  input  logic              take,
  output logic              pend,
  output logic [BYTE_W-1:0] hold_byte,
  output logic              hold_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      hold_byte <= '0;
      hold_end  <= 1'b0;
    end else if (load) begin
      pend      <= 1'b1;
      hold_byte <= load_byte;
      hold_end  <= load_end;
    end else if (pend && take) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ws_outbound.sv
module ws_outbound #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_clear,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_byte,
  output logic              pend,
  output logic              done,
  output logic              rrdy,
  output logic [BYTE_W-1:0] held
);
  assign done = pend && src_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      rrdy <= 1'b0;
      held <= '0;
    end else begin
      if (start)     pend <= 1'b1;
      else if (done) pend <= 1'b0;
      if (done) begin
        held <= src_byte;
        rrdy <= 1'b1;
      end else if (rd_clear) begin
        rrdy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ws_responder.sv
module ws_responder #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] RESP_OFF = 6'h0A,
  parameter logic [ADDR_W-1:0] DLOW_OFF = 6'h0E
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [ws_pkg::BUS_W-1:0]  bus_wdata,
  output logic [ws_pkg::BUS_W-1:0]  bus_rdata,
  output logic                      bus_err,
  output logic                      in_valid,
  output logic [ws_pkg::BYTE_W-1:0] in_data,
  output logic                      in_end,
  input  logic                      in_take,
  input  logic                      out_valid,
  input  logic [ws_pkg::BYTE_W-1:0] out_data,
  output logic                      out_take,
  output logic                      cmd_err
);
  import ws_pkg::*;

  logic              hit_resp, hit_dlow, miss;
  logic              dl_wr, dl_rd;
  ws_cmd_e           cmd;
  logic              wr_rdy, rd_rdy;
  logic              bavl_go, breq_go, err_set;
  logic              fetch_pend, fetch_done;
  logic [BYTE_W-1:0] out_held;

  ws_addr_dec #(.ADDR_W(ADDR_W), .RESP_OFF(RESP_OFF), .DLOW_OFF(DLOW_OFF)) u_dec (
    .sel(bus_sel), .addr(bus_addr),
    .hit_resp(hit_resp), .hit_dlow(hit_dlow), .miss(miss)
  );

  always_comb begin
    cmd     = classify(bus_wdata);
    dl_wr   = hit_dlow && bus_wr;
    dl_rd   = hit_dlow && !bus_wr;
    bavl_go = dl_wr && wr_rdy && (cmd == WS_CMD_BAVL) && !in_valid;
    breq_go = dl_wr && wr_rdy && (cmd == WS_CMD_BREQ) && out_valid;
    err_set = dl_wr && (!wr_rdy || (cmd == WS_CMD_BAD) ||
                        ((cmd == WS_CMD_BAVL) && in_valid));
  end

  ws_inbound #(.BYTE_W(BYTE_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .load(bavl_go), .load_byte(bus_wdata[BYTE_W-1:0]), .load_end(bus_wdata[8]),
    .take(in_take),
    .pend(in_valid), .hold_byte(in_data), .hold_end(in_end)
  );

  ws_outbound #(.BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .start(breq_go), .rd_clear(dl_rd),
    .src_valid(out_valid), .src_byte(out_data),
    .pend(fetch_pend), .done(fetch_done), .rrdy(rd_rdy), .held(out_held)
  );

  assign out_take = fetch_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_rdy  <= 1'b1;
      cmd_err <= 1'b0;
    end else begin
      if (bavl_go || breq_go)          wr_rdy <= 1'b0;
      else if (!fetch_pend || fetch_done) wr_rdy <= 1'b1;
      if (err_set) cmd_err <= 1'b1;
    end
  end

  always_comb begin
    bus_err   = miss;
    bus_rdata = '0;
    if (hit_resp)      bus_rdata = resp_word(out_valid, !in_valid, rd_rdy, wr_rdy);
    else if (hit_dlow) bus_rdata = {{(BUS_W-BYTE_W){1'b0}}, out_held};
  end
endmodule

// File: rtl/ws_responder_chk.sv
module ws_responder_chk (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic           bus_err,
  input logic           hit_dlow,
  input ws_pkg::ws_cmd_e cmd,
  input logic           wr_rdy,
  input logic           rd_rdy,
  input logic           fetch_pend,
  input logic           fetch_done,
  input logic           bavl_go,
  input logic           breq_go,
  input logic           in_valid,
  input logic           in_take,
  input logic [7:0]     in_data,
  input logic           out_valid,
  input logic           out_take,
  input logic           cmd_err
);
  // R7
  miss_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !bavl_go && !breq_go && !hit_dlow);
  // R7
  miss_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err && !cmd_err |=> !cmd_err);
  // R2
  bavl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bavl_go |=> in_valid);
  // R3
  bavl_wrdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bavl_go |=> !wr_rdy ##1 wr_rdy);
  // R4
  breq_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    breq_go && !fetch_pend |=> !wr_rdy && (out_take || !out_valid));
  // R4
  fetch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> rd_rdy && wr_rdy && !fetch_pend);
  // R4
  take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_take |-> out_valid);
  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && hit_dlow && !fetch_done |=> !rd_rdy);
  // R6
  breq_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && hit_dlow && (cmd == ws_pkg::WS_CMD_BREQ) && !out_valid && !fetch_pend
      |=> !fetch_pend);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
  // R11
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_take |=> in_valid && $stable(in_data));
endmodule

bind ws_responder ws_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_err(bus_err),
  .hit_dlow(hit_dlow), .cmd(cmd), .wr_rdy(wr_rdy), .rd_rdy(rd_rdy),
  .fetch_pend(fetch_pend), .fetch_done(fetch_done), .bavl_go(bavl_go), .breq_go(breq_go),
  .in_valid(in_valid), .in_take(in_take), .in_data(in_data),
  .out_valid(out_valid), .out_take(out_take), .cmd_err(cmd_err)
);

// File: tb/ws_responder_bench.sv
module ws_responder_bench;
  localparam logic [5:0] RESP = 6'h0A;
  localparam logic [5:0] DLOW = 6'h0E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic        in_valid, in_end, in_take = 1'b0;
  logic [7:0]  in_data;
  logic        out_valid = 1'b0;
  logic [7:0]  out_data = '0;
  logic        out_take, cmd_err;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  ws_responder u_ws_responder (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .in_valid(in_valid), .in_data(in_data), .in_end(in_end), .in_take(in_take),
    .out_valid(out_valid), .out_data(out_data), .out_take(out_take), .cmd_err(cmd_err)
  );

  // Bench's own model of the status word
  function automatic logic [15:0] exp_resp(input logic dor, input logic dir,
                                           input logic rr, input logic wr);
    logic [15:0] v = 16'hFFFF;
    if (!dor) v = v & ~16'h2000;
    if (!dir) v = v & ~16'h1000;
    if (!rr)  v = v & ~16'h0400;
    if (!wr)  v = v & ~16'h0200;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All bus tasks are entered at a negedge and return at the next negedge.
  task automatic bus_write(input logic [5:0] a, input logic [15:0] d, output logic err);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #2 err = bus_err;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d, output logic err);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 begin d = bus_rdata; err = bus_err; end
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d; logic e;
    chk("R1 in_valid after reset", {15'b0, in_valid}, 16'h0);
    chk("R1 cmd_err after reset", {15'b0, cmd_err}, 16'h0);
    bus_read(RESP, d, e);
    chk("R1 reset response", d, 16'hDBFF);
    chk("R7 no bus_err on Response", {15'b0, e}, 16'h0);
    out_valid = 1'b1;
    bus_read(RESP, d, e);
    chk("R1 DOR bit13", d, exp_resp(1, 1, 0, 1));
    out_valid = 1'b0;
  endtask

  task automatic t_byte_avail;
    logic [15:0] d; logic e;
    bus_write(DLOW, 16'hBC5A, e);
    chk("R7 no bus_err on Data Low", {15'b0, e}, 16'h0);
    chk("R2 in_valid", {15'b0, in_valid}, 16'h1);
    chk("R2 in_data", {8'h0, in_data}, 16'h005A);
    chk("R2 in_end BC", {15'b0, in_end}, 16'h0);
    bus_read(RESP, d, e);
    chk("R3 Write Ready low one cycle", d, exp_resp(0, 0, 0, 0));
    bus_read(RESP, d, e);
    chk("R3 Write Ready back", d, exp_resp(0, 0, 0, 1));
    chk("R11 byte held", {8'h0, in_data}, 16'h005A);
    in_take = 1'b1; @(negedge clk); in_take = 1'b0;
    chk("R11 in_valid cleared", {15'b0, in_valid}, 16'h0);
    bus_read(RESP, d, e);
    chk("R11 DIR back", d, 16'hDBFF);
    bus_write(DLOW, 16'hBD3C, e);
    chk("R2 in_data BD", {8'h0, in_data}, 16'h003C);
    chk("R2 in_end BD", {15'b0, in_end}, 16'h1);
    @(negedge clk);
    in_take = 1'b1; @(negedge clk); in_take = 1'b0;
  endtask

  task automatic t_byte_req;
    logic [15:0] d; logic e;
    out_valid = 1'b1; out_data = 8'hA7;
    bus_write(DLOW, 16'hDEFF, e);
    chk("R4 out_take pulse", {15'b0, out_take}, 16'h1);
    bus_read(RESP, d, e);
    chk("R4 waiting for latch", d, exp_resp(1, 1, 0, 0));
    out_valid = 1'b0; out_data = 8'h11;
    chk("R4 out_take one cycle", {15'b0, out_take}, 16'h0);
    bus_read(RESP, d, e);
    chk("R4 ready flags after latch", d, exp_resp(0, 1, 1, 1));
    bus_read(DLOW, d, e);
    chk("R5 Data Low byte", d, 16'h00A7);
    bus_read(RESP, d, e);
    chk("R5 Read Ready cleared", d, 16'hDBFF);
  endtask

  task automatic t_req_empty;
    logic [15:0] d; logic e;
    bus_write(DLOW, 16'hDEFF, e);
    chk("R6 no out_take", {15'b0, out_take}, 16'h0);
    bus_read(RESP, d, e);
    chk("R6 flags unchanged", d, 16'hDBFF);
    chk("R6 no cmd_err", {15'b0, cmd_err}, 16'h0);
    @(negedge clk);
    bus_read(RESP, d, e);
    chk("R6 still idle", d, 16'hDBFF);
  endtask

  task automatic t_resp_write;
    logic [15:0] d; logic e;
    bus_write(RESP, 16'h0000, e);
    bus_read(RESP, d, e);
    chk("R10 response unchanged", d, 16'hDBFF);
    chk("R10 no cmd_err", {15'b0, cmd_err}, 16'h0);
  endtask

  task automatic t_bad_offset;
    logic [15:0] d; logic e;
    bus_read(6'h00, d, e);
    chk("R7 bus_err on read", {15'b0, e}, 16'h1);
    chk("R7 read data zero", d, 16'h0000);
    out_valid = 1'b1; out_data = 8'h42;
    bus_write(6'h3F, 16'hDEFF, e);
    chk("R7 bus_err on write", {15'b0, e}, 16'h1);
    chk("R7 no fetch", {15'b0, out_take}, 16'h0);
    bus_write(6'h0C, 16'hBC77, e);
    chk("R7 no inbound load", {15'b0, in_valid}, 16'h0);
    bus_read(RESP, d, e);
    chk("R7 flags unchanged", d, exp_resp(1, 1, 0, 1));
    chk("R7 no cmd_err", {15'b0, cmd_err}, 16'h0);
    out_valid = 1'b0;
  endtask

  task automatic t_bad_code;
    logic [15:0] d; logic e;
    bus_write(DLOW, 16'h1234, e);
    chk("R8 cmd_err set", {15'b0, cmd_err}, 16'h1);
    chk("R8 nothing loaded", {15'b0, in_valid}, 16'h0);
    bus_read(RESP, d, e);
    chk("R8 flags unchanged", d, 16'hDBFF);
    chk("R8 cmd_err sticky", {15'b0, cmd_err}, 16'h1);
  endtask

  task automatic t_overrun;
    logic [15:0] d; logic e;
    bus_write(DLOW, 16'hBC66, e);
    @(negedge clk);
    bus_write(DLOW, 16'hBDAA, e);
    chk("R9 pending byte kept", {8'h0, in_data}, 16'h0066);
    chk("R9 end flag kept", {15'b0, in_end}, 16'h0);
    bus_read(RESP, d, e);
    chk("R9 Write Ready stays", d, exp_resp(0, 0, 0, 1));
    in_take = 1'b1; @(negedge clk); in_take = 1'b0;
    out_valid = 1'b1; out_data = 8'h99;
    bus_write(DLOW, 16'hBC01, e);
    bus_write(DLOW, 16'hDEFF, e);
    chk("R9 request while Write Ready low dropped", {15'b0, out_take}, 16'h0);
    chk("R9 earlier byte kept", {8'h0, in_data}, 16'h0001);
    out_valid = 1'b0;
  endtask

  task automatic t_rereset;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R8 cmd_err cleared by reset", {15'b0, cmd_err}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_avail();
    t_byte_req();
    t_req_empty();
    t_resp_write();
    t_bad_offset();
    t_bad_code();
    t_overrun();
    t_rereset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule